// File: doc/BRIEF.md
# Pseudo-Associative Read Cache

This block is a read-only, direct-mapped cache with one backup slot per address. A read is looked up first in its home set. If that misses, the cache tries a partner set, the set whose index differs only in its most significant bit. It declares a miss only when both sets miss. A hit in the home set answers one cycle after the request is accepted. A hit in the partner set answers one cycle later. On that slower hit the two lines trade places, so that a line in use sits in its home set.

A true miss sends one line request to a simple memory model. The model returns the line one word per beat, lowest word first. The new line is written into the home set. The line that occupied the home set moves to the partner set, and whatever was in the partner set is discarded. Because lines move home again on every partner hit, they do not pile up in backup slots. The stored tag keeps the top index bit, which makes it possible to tell a line resting in its partner slot from a line at home.

Top module: `pac_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. The first read of any address is a miss.
- R2: A read whose line is in its home set (index = address bits [7:2]) raises `rsp_valid` for one cycle, one cycle after acceptance. It carries the addressed word (word offset = address bits [1:0]) and issues no memory request.
- R3: A read that misses its home set probes the partner set (index with bit 5 inverted). On a hit there the response comes two cycles after acceptance, with no memory request.
- R4: After a partner hit the accessed line is in its home set and the line previously in the home set is in the partner set. The next read of the first line is a one-cycle hit, and the next read of the second line is a two-cycle hit.
- R5: On a miss in both sets, exactly one single-cycle `mem_req_valid` pulse is issued, with `mem_req_addr` = address bits [15:2]. Four beats are then accepted, word 0 first. The response carries the requested word and arrives after the last beat.
- R6: On a refill, a valid line previously in the home set moves to the partner set and the former partner line is dropped, so its next read misses.
- R7: The stored tag (address bits [15:7]) includes the top index bit. An address whose home set is another line's partner set never hits on that line.
- R8: `req_ready` is 0 while a partner probe or a refill is in progress.
- R9: Each accepted request yields exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Word address of the read |
| req_ready | output | 1 | Cache idle and accepting a request |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Line fetch request pulse |
| mem_req_addr | output | 14 | Line address to fetch |
| mem_rsp_valid | input | 1 | Refill beat valid |
| mem_rsp_data | input | 32 | Refill beat data |

## Verification
The bench targets pairs of addresses that share a home set or sit in each other's partner set. These pairs expose a design that inverts the wrong index bit, or that leaves the top index bit out of the tag; such a design reports false partner hits or false home hits on a line parked in its backup slot. Directed sequences check that a partner hit swaps the two lines, so a design that skips the swap keeps answering in two cycles. They also check that a refill pushes the old home line into the partner slot and drops the former occupant; a design that got this wrong would miss on the pushed line or keep returning the stale one. Randomised traffic over a few conflicting sets checks latency class, data word and memory request count against an independent model.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int unsigned PAC_ADDR_W     = 16;
  localparam int unsigned PAC_WORD_W     = 32;
  localparam int unsigned PAC_SETS       = 64;
  localparam int unsigned PAC_LINE_WORDS = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE  = 2'd1,
    ST_REFILL = 2'd2
  } pac_state_e;
endpackage

// File: rtl/pac_store.sv
module pac_store #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned TAG_W  = 9,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [LINE_W-1:0] a_line,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output logic [LINE_W-1:0] b_line,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic              wa_valid,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [LINE_W-1:0] wa_line,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [LINE_W-1:0] wb_line
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [LINE_W-1:0] dat_q [SETS];

  assign a_valid = vld_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_line  = dat_q[a_idx];
  assign b_valid = vld_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_line  = dat_q[b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (wa_en) vld_q[wa_idx] <= wa_valid;
      if (wb_en) vld_q[wb_idx] <= wb_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) begin
      tag_q[wa_idx] <= wa_tag;
      dat_q[wa_idx] <= wa_line;
    end
    if (wb_en) begin
      tag_q[wb_idx] <= wb_tag;
      dat_q[wb_idx] <= wb_line;
    end
  end

  // R4 R6: a swap or displacement always targets two different sets
  assert_ports_disjoint_R6: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
endmodule

// File: rtl/pac_fill.sv
module pac_fill #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned LINE_W    = WORD_W * LINE_WORDS,
  localparam int unsigned CNT_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              active,
  input  logic              beat_valid,
  input  logic [WORD_W-1:0] beat_data,
  output logic              last,
  output logic [LINE_W-1:0] line
);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(LINE_WORDS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] words_q [LINE_WORDS-1];

  assign last = beat_valid && (cnt_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (beat_valid) cnt_q <= cnt_q + 1'b1;
  end

  generate
    for (genvar w = 0; w < LINE_WORDS - 1; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (beat_valid && cnt_q == CNT_W'(w)) words_q[w] <= beat_data;
      end
      assign line[w*WORD_W +: WORD_W] = words_q[w];
    end
  endgenerate
  assign line[(LINE_WORDS-1)*WORD_W +: WORD_W] = beat_data;

  // R5: refill beats only arrive while a refill is outstanding
  assert_beat_in_refill_R5: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> active);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned SETS       = 64,
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(SETS),
  localparam int unsigned TAG_W     = ADDR_W - OFF_W - IDX_W + 1,
  localparam int unsigned LINE_W    = WORD_W * LINE_WORDS,
  localparam int unsigned LADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               mem_req_valid,
  output logic [LADDR_W-1:0] mem_req_addr,
  output logic [IDX_W-1:0]   a_idx,
  input  logic               a_valid,
  input  logic [TAG_W-1:0]   a_tag,
  input  logic [LINE_W-1:0]  a_line,
  output logic [IDX_W-1:0]   b_idx,
  input  logic               b_valid,
  input  logic [TAG_W-1:0]   b_tag,
  input  logic [LINE_W-1:0]  b_line,
  output logic               wa_en,
  output logic [IDX_W-1:0]   wa_idx,
  output logic               wa_valid,
  output logic [TAG_W-1:0]   wa_tag,
  output logic [LINE_W-1:0]  wa_line,
  output logic               wb_en,
  output logic [IDX_W-1:0]   wb_idx,
  output logic               wb_valid,
  output logic [TAG_W-1:0]   wb_tag,
  output logic [LINE_W-1:0]  wb_line,
  output logic               fill_start,
  output logic               fill_active,
  input  logic               fill_last,
  input  logic [LINE_W-1:0]  fill_line
);
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_partner(input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] m;
    m = '0;
    m[IDX_W-1] = 1'b1;
    return i ^ m;
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 : OFF_W+IDX_W-1];
  endfunction

  function automatic logic [WORD_W-1:0] f_word(input logic [LINE_W-1:0] l,
                                               input logic [OFF_W-1:0] off);
    return l[off*WORD_W +: WORD_W];
  endfunction

  pac_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] look_addr;
  logic              home_match, partner_match;
  logic              accept;
  logic              evt_home_hit, evt_home_miss, evt_partner_hit, evt_miss, evt_fill_done;

  assign req_ready   = (state_q == ST_IDLE);
  assign look_addr   = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign a_idx       = f_idx(look_addr);
  assign b_idx       = f_partner(a_idx);

  assign home_match    = a_valid && (a_tag == f_tag(look_addr));
  assign partner_match = b_valid && (b_tag == f_tag(look_addr));

  assign accept          = req_ready && req_valid;
  assign evt_home_hit    = accept && home_match;
  assign evt_home_miss   = accept && !home_match;
  assign evt_partner_hit = (state_q == ST_PROBE) && partner_match;
  assign evt_miss        = (state_q == ST_PROBE) && !partner_match;
  assign evt_fill_done   = (state_q == ST_REFILL) && fill_last;

  assign fill_start  = evt_miss;
  assign fill_active = (state_q == ST_REFILL);

  always_comb begin
    wa_en    = evt_partner_hit || evt_fill_done;
    wa_idx   = a_idx;
    wa_valid = 1'b1;
    wa_tag   = evt_partner_hit ? b_tag : f_tag(addr_q);
    wa_line  = evt_partner_hit ? b_line : fill_line;
    wb_en    = evt_partner_hit || (evt_fill_done && a_valid);
    wb_idx   = b_idx;
    wb_valid = a_valid;
    wb_tag   = a_tag;
    wb_line  = a_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      rsp_valid     <= evt_home_hit || evt_partner_hit || evt_fill_done;
      mem_req_valid <= evt_miss;
      if (accept) addr_q <= req_addr;
      if (evt_home_hit)    rsp_data <= f_word(a_line, look_addr[OFF_W-1:0]);
      if (evt_partner_hit) rsp_data <= f_word(b_line, addr_q[OFF_W-1:0]);
      if (evt_fill_done)   rsp_data <= f_word(fill_line, addr_q[OFF_W-1:0]);
      if (evt_miss) mem_req_addr <= addr_q[ADDR_W-1:OFF_W];
      unique case (state_q)
        ST_IDLE:   if (evt_home_miss) state_q <= ST_PROBE;
        ST_PROBE:  state_q <= evt_miss ? ST_REFILL : ST_IDLE;
        ST_REFILL: if (evt_fill_done) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a partner hit answers next cycle without touching memory
  assert_partner_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    evt_partner_hit |=> (rsp_valid && !mem_req_valid));
  // R5: a double miss issues the line request on the next cycle
  assert_miss_request_R5: assert property (@(posedge clk) disable iff (rst)
    evt_miss |=> mem_req_valid);
  // R5: line request is a single-cycle pulse
  assert_memreq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R5: completion of a refill produces the response
  assert_fill_response_R5: assert property (@(posedge clk) disable iff (rst)
    evt_fill_done |=> rsp_valid);
  // R8: a home miss makes the cache busy on the following cycle
  assert_busy_after_miss_R8: assert property (@(posedge clk) disable iff (rst)
    evt_home_miss |=> !req_ready);
  // R9: at most one lookup outcome per cycle
  assert_single_event_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_home_hit, evt_partner_hit, evt_miss, evt_fill_done}));
  // R2: a home hit never starts a memory request
  assert_home_hit_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    evt_home_hit |=> (rsp_valid && !mem_req_valid));
endmodule

// File: rtl/pac_cache.sv
module pac_cache
  import pac_pkg::*;
#(
  parameter int unsigned ADDR_W     = PAC_ADDR_W,
  parameter int unsigned WORD_W     = PAC_WORD_W,
  parameter int unsigned SETS       = PAC_SETS,
  parameter int unsigned LINE_WORDS = PAC_LINE_WORDS,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(SETS),
  localparam int unsigned TAG_W     = ADDR_W - OFF_W - IDX_W + 1,
  localparam int unsigned LINE_W    = WORD_W * LINE_WORDS,
  localparam int unsigned LADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               mem_req_valid,
  output logic [LADDR_W-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_data
);
  logic [IDX_W-1:0]  a_idx, b_idx, wa_idx, wb_idx;
  logic              a_valid, b_valid, wa_en, wb_en, wa_valid, wb_valid;
  logic [TAG_W-1:0]  a_tag, b_tag, wa_tag, wb_tag;
  logic [LINE_W-1:0] a_line, b_line, wa_line, wb_line, fill_line;
  logic              fill_start, fill_active, fill_last;

  pac_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_line(a_line),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_line(b_line),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_valid(wa_valid), .wa_tag(wa_tag), .wa_line(wa_line),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_line(wb_line),
    .fill_start(fill_start), .fill_active(fill_active),
    .fill_last(fill_last), .fill_line(fill_line)
  );

  pac_store #(
    .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_line(a_line),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_line(b_line),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_valid(wa_valid), .wa_tag(wa_tag), .wa_line(wa_line),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_line(wb_line)
  );

  pac_fill #(
    .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
  ) u_fill (
    .clk(clk), .rst(rst),
    .start(fill_start), .active(fill_active),
    .beat_valid(mem_rsp_valid), .beat_data(mem_rsp_data),
    .last(fill_last), .line(fill_line)
  );
endmodule

// File: tb/test_pac_cache.sv
`timescale 1ns/100ps
module test_pac_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic [13:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int mem_reqs = 0;
  logic [13:0] last_mem_addr = '0;
  bit done = 0;

  // bench model: per set, valid bit and resident line address
  bit          bm_valid [64];
  logic [13:0] bm_line  [64];

  always #2.5 clk = ~clk;

  pac_cache i_pac_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [13:0] ln, input logic [1:0] w);
    return {8'h5A, 2'b00, ln, 6'b000000, w};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: answers each line request with four ascending beats
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        mem_reqs++;
        last_mem_addr = mem_req_addr;
        repeat (2) @(negedge clk);
        for (int w = 0; w < 4; w++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(last_mem_addr, 2'(w));
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // kind: 0 home hit, 1 partner hit, 2 miss; model updated here
  function automatic int predict(input logic [15:0] a);
    logic [13:0] ln;
    logic [5:0]  p, s;
    bit          tv;
    logic [13:0] tl;
    ln = a[15:2];
    p  = ln[5:0];
    s  = {~p[5], p[4:0]};
    if (bm_valid[p] && bm_line[p] == ln) return 0;
    if (bm_valid[s] && bm_line[s] == ln) begin
      tv = bm_valid[p]; tl = bm_line[p];
      bm_valid[p] = 1'b1; bm_line[p] = ln;
      bm_valid[s] = tv;   bm_line[s] = tl;
      return 1;
    end
    if (bm_valid[p]) begin
      bm_valid[s] = 1'b1; bm_line[s] = bm_line[p];
    end
    bm_valid[p] = 1'b1; bm_line[p] = ln;
    return 2;
  endfunction

  task automatic access(input logic [15:0] a, input string tag);
    int kind, cyc, reqs0;
    string rq;
    kind  = predict(a);
    rq    = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R5";
    reqs0 = mem_reqs;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (!rsp_valid) check(req_ready == 1'b0, "R8", {tag, " busy while pending"}, 32'(req_ready), 0);
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (kind == 0) check(cyc == 1, rq, {tag, " home-hit latency"}, 32'(cyc), 1);
    else if (kind == 1) check(cyc == 2, rq, {tag, " partner-hit latency"}, 32'(cyc), 2);
    else check(cyc > 2 && cyc < 100, rq, {tag, " miss latency"}, 32'(cyc), 8);
    check(rsp_data == mem_word(a[15:2], a[1:0]), rq, {tag, " data"}, rsp_data, mem_word(a[15:2], a[1:0]));
    check(mem_reqs - reqs0 == ((kind == 2) ? 1 : 0), rq, {tag, " memory requests"},
          32'(mem_reqs - reqs0), (kind == 2) ? 1 : 0);
    if (kind == 2) check(last_mem_addr == a[15:2], "R5", {tag, " line address"}, 32'(last_mem_addr), 32'(a[15:2]));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", {tag, " single response pulse"}, 32'(rsp_valid), 0);
  endtask

  function automatic int kind_now(input logic [15:0] a);
    logic [13:0] ln;
    logic [5:0]  p, s;
    ln = a[15:2]; p = ln[5:0]; s = {~p[5], p[4:0]};
    if (bm_valid[p] && bm_line[p] == ln) return 0;
    if (bm_valid[s] && bm_line[s] == ln) return 1;
    return 2;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] a_addr, b_addr, c_addr;
    logic [5:0]  pick [4];
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) begin bm_valid[i] = 0; bm_line[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R1", "no memory request after reset", 32'(mem_req_valid), 0);

    a_addr = {8'h01, 6'd5, 2'd2};
    b_addr = {8'h02, 6'd5, 2'd1};
    c_addr = {8'h01, 6'd37, 2'd3};
    check(kind_now(a_addr) == 2, "R1", "cold access predicted miss", 0, 2);
    access(a_addr, "R1 cold");
    access({a_addr[15:2], 2'd0}, "R2 reread");
    access(b_addr, "R6 conflict");
    // R6: A was pushed to its partner set, so it is a partner hit
    check(kind_now(a_addr) == 1, "R6", "displaced line in partner", 32'(kind_now(a_addr)), 1);
    access(a_addr, "R3 partner");
    // R4: after swap A is home, B is in the partner slot
    check(kind_now(a_addr) == 0 && kind_now(b_addr) == 1, "R4", "swap prediction", 0, 0);
    access(a_addr, "R4 home after swap");
    access(b_addr, "R4 old home now partner");
    // R7: C has A's upper tag and the other top index bit; no false match
    access(c_addr, "R7 alias");
    access(b_addr, "R6 dropped line");
    access(a_addr, "R7 after alias");
    access(c_addr, "R7 alias again");

    pick[0] = 6'd3; pick[1] = 6'd35; pick[2] = 6'd10; pick[3] = 6'd42;
    for (int n = 0; n < 300; n++) begin
      logic [15:0] ra;
      ra = {8'($urandom % 3), pick[$urandom % 4], 2'($urandom % 4)};
      access(ra, "random");
    end
    finish_run();
  end
endmodule